// File: doc/BRIEF.md
# Feed-Protected PLL Control Register Unit

This block sits on a simple register bus and holds the software-visible enable, connect and divider/multiplier settings of a clock synthesizer. Writes to the control and configuration registers land in a pending copy only. The pending copy moves into the active copy, which drives the clock logic, only when software performs an unlock: a byte 0xAA written to the feed register, then a byte 0x55, with no other access to the protected 16 KiB window in between. A wrong byte or an intervening access in the window throws the attempt away.

The active outputs are the enable bit, an effective connect bit, the active configuration word and a clock-select signal. Connect has no effect while enable is low. The clock-select is only raised once the synthesizer reports lock. A power-down request clears the active enable and connect. The active copy stays cleared until software feeds again. The pending copy is kept.

Top module: `pllfeed_unit`

Register map (addresses absolute, window 0x400FC000 to 0x400FFFFF): CTRL at 0x400FC000 (bit 0 enable, bit 1 connect), CFG at 0x400FC004 (32-bit word), STAT at 0x400FC008 (bit 0 active enable, bit 1 effective connect, bit 2 lock), FEED at 0x400FC00C (8-bit, only wdata[7:0] counts).

## Requirements
- R1: While reset is high, and at the first edge after it, all active outputs are 0, the pending registers are 0, rdata is 0 and the unlock sequence is idle.
- R2: A write to CTRL or CFG changes only the pending copy. pll_enable, pll_connect and pll_cfg are unchanged. A read of CTRL returns {connect, enable} in bits 1:0 and a read of CFG returns the pending word.
- R3: A FEED write of 0xAA followed by a FEED write of 0x55 copies the pending values into the active outputs at the edge that samples the 0x55 write. Idle cycles with no access may lie between the two writes.
- R4: Any other read or write inside the window between the two feed writes cancels the unlock. This includes a read of FEED or an access to an unmapped address such as 0x400FC100. The active values stay unchanged.
- R5: The unlock fails if the first byte is not 0xAA or the second byte is neither 0x55 nor 0xAA. The active values then stay unchanged.
- R6: A 0xAA FEED write while waiting for 0x55 keeps the sequence waiting, so 0xAA, 0xAA, 0x55 unlocks.
- R7: Bus accesses outside the window, such as 0x400FBFFC or 0x40100000, do not cancel a pending unlock.
- R8: pll_connect is 1 only when both the active connect and the active enable bits are 1. Committing connect=1 with enable=0 gives pll_enable=0 and pll_connect=0.
- R9: clk_sel is 1 exactly when pll_enable, pll_connect and lock_in are all 1. It follows lock_in without a register stage.
- R10: pd_req clears pll_enable and pll_connect at the next edge and wins over a simultaneous commit. pll_cfg and the pending values are kept, and the outputs stay cleared until the next successful unlock.
- R11: rdata is registered and appears the cycle after a read. STAT returns {lock, effective connect, active enable} in bits 2:0. FEED, unmapped addresses and addresses outside the window read as 0. rdata is 0 in a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Bus byte address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| lock_in | input | 1 | Lock indication from the synthesizer |
| pd_req | input | 1 | Power-down request |
| pll_enable | output | 1 | Active enable |
| pll_connect | output | 1 | Effective connect (active connect and enable) |
| pll_cfg | output | 32 | Active configuration word |
| clk_sel | output | 1 | Select the synthesized clock |

## Verification
Pending writes, commits and power-down clears all take effect at the edge that samples the bus cycle, so they are visible one edge after the stimulus. Read data is due one edge after the read strobe and drops back to 0 at the following edge. clk_sel responds to lock_in in the same cycle. The bench drives inputs just after a rising edge and compares every output with its behavioural model at the falling edge. The directed checks are taken right after the edge that carries the stimulus, which keeps every check inside the cycle where the result is defined.

// File: rtl/pllfeed_pkg.sv
package pllfeed_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int OFS_CTRL = 'h000;
    localparam int OFS_CFG  = 'h004;
    localparam int OFS_STAT = 'h008;
    localparam int OFS_FEED = 'h00C;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_CFG,
        REG_STAT,
        REG_FEED,
        REG_HOLE
    } region_t;

    typedef enum logic [0:0] {
        FEED_IDLE,
        FEED_ARMED
    } feed_state_t;

    typedef struct packed {
        logic connect;
        logic enable;
    } ctrl_t;

    function automatic logic [2:0] status_bits(input ctrl_t eff, input logic lock);
        return {lock, eff.connect, eff.enable};
    endfunction

endpackage

// File: rtl/pllfeed_decode.sv
module pllfeed_decode
    import pllfeed_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              WIN_BITS = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h400F_C000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output region_t           kind
);
    localparam logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

    logic                in_win;
    logic [WIN_BITS-1:0] ofs;

    assign in_win = (addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
    assign ofs    = addr[WIN_BITS-1:0];

    always_comb begin
        kind = REG_NONE;
        if ((we || re) && in_win) begin
            if      (ofs == WIN_BITS'(OFS_CTRL)) kind = REG_CTRL;
            else if (ofs == WIN_BITS'(OFS_CFG))  kind = REG_CFG;
            else if (ofs == WIN_BITS'(OFS_STAT)) kind = REG_STAT;
            else if (ofs == WIN_BITS'(OFS_FEED)) kind = REG_FEED;
            else                                 kind = REG_HOLE;
        end
    end
endmodule

// File: rtl/pllfeed_unlock.sv
module pllfeed_unlock
    import pllfeed_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  region_t    kind,
    input  logic       we,
    input  logic [7:0] feed_byte,
    output logic       commit
);
    feed_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        commit    = 1'b0;
        if (kind != REG_NONE) begin
            if (we && kind == REG_FEED) begin
                if (feed_byte == KEY_FIRST) begin
                    state_nxt = FEED_ARMED;
                end else begin
                    commit    = (state == FEED_ARMED) && (feed_byte == KEY_SECOND);
                    state_nxt = FEED_IDLE;
                end
            end else begin
                state_nxt = FEED_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FEED_IDLE;
        else     state <= state_nxt;
    end
endmodule

// File: rtl/pllfeed_regbank.sv
module pllfeed_regbank
    import pllfeed_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  region_t           kind,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    input  logic              pd_req,
    output ctrl_t             pend_ctrl,
    output logic [DATA_W-1:0] pend_cfg,
    output ctrl_t             act_ctrl,
    output logic [DATA_W-1:0] act_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ctrl <= '0;
            pend_cfg  <= '0;
        end else if (we) begin
            if (kind == REG_CTRL) pend_ctrl <= ctrl_t'(wdata[1:0]);
            if (kind == REG_CFG)  pend_cfg  <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ctrl <= '0;
            act_cfg  <= '0;
        end else begin
            if (commit) begin
                act_ctrl <= pend_ctrl;
                act_cfg  <= pend_cfg;
            end
            if (pd_req) act_ctrl <= '0;
        end
    end
endmodule

// File: rtl/pllfeed_readback.sv
module pllfeed_readback
    import pllfeed_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  logic              we,
    input  region_t           kind,
    input  ctrl_t             pend_ctrl,
    input  logic [DATA_W-1:0] pend_cfg,
    input  ctrl_t             eff_ctrl,
    input  logic              lock_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_nxt;

    always_comb begin
        rd_nxt = '0;
        if (re && !we) begin
            unique case (kind)
                REG_CTRL: rd_nxt = DATA_W'(pend_ctrl);
                REG_CFG:  rd_nxt = pend_cfg;
                REG_STAT: rd_nxt = DATA_W'(status_bits(eff_ctrl, lock_in));
                default:  rd_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_nxt;
    end
endmodule

// File: rtl/pllfeed_unit.sv
module pllfeed_unit
    import pllfeed_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                WIN_BITS = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h400F_C000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    input  logic              lock_in,
    input  logic              pd_req,
    output logic              pll_enable,
    output logic              pll_connect,
    output logic [DATA_W-1:0] pll_cfg,
    output logic              clk_sel
);
    region_t kind;
    logic    commit;
    ctrl_t   pend_ctrl, act_ctrl, eff_ctrl;
    logic [DATA_W-1:0] pend_cfg;

    pllfeed_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr(addr), .we(we), .re(re), .kind(kind)
    );

    pllfeed_unlock u_unlock (
        .clk(clk), .rst(rst), .kind(kind), .we(we),
        .feed_byte(wdata[7:0]), .commit(commit)
    );

    pllfeed_regbank #(.DATA_W(DATA_W)) u_regbank (
        .clk(clk), .rst(rst), .kind(kind), .we(we), .wdata(wdata),
        .commit(commit), .pd_req(pd_req),
        .pend_ctrl(pend_ctrl), .pend_cfg(pend_cfg),
        .act_ctrl(act_ctrl), .act_cfg(pll_cfg)
    );

    always_comb begin
        eff_ctrl.enable  = act_ctrl.enable;
        eff_ctrl.connect = act_ctrl.connect & act_ctrl.enable;
    end

    assign pll_enable  = eff_ctrl.enable;
    assign pll_connect = eff_ctrl.connect;
    assign clk_sel     = eff_ctrl.connect & lock_in;

    pllfeed_readback #(.DATA_W(DATA_W)) u_readback (
        .clk(clk), .rst(rst), .re(re), .we(we), .kind(kind),
        .pend_ctrl(pend_ctrl), .pend_cfg(pend_cfg),
        .eff_ctrl(eff_ctrl), .lock_in(lock_in), .rdata(rdata)
    );
endmodule

// File: rtl/pllfeed_unit_chk.sv
module pllfeed_unit_chk
    import pllfeed_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h400F_C000
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [7:0]        wbyte,
    input logic              re,
    input logic [DATA_W-1:0] rdata,
    input logic              lock_in,
    input logic              pd_req,
    input logic              pll_enable,
    input logic              pll_connect,
    input logic [DATA_W-1:0] pll_cfg,
    input logic              clk_sel
);
    localparam logic [ADDR_W-1:0] FEED_ADDR = WIN_BASE + ADDR_W'(OFS_FEED);
    localparam logic [ADDR_W-1:0] STAT_ADDR = WIN_BASE + ADDR_W'(OFS_STAT);

    logic second_key;
    assign second_key = we && (addr == FEED_ADDR) && (wbyte == KEY_SECOND);

    // R3: the active word moves only at an edge that samples a 0x55 feed write
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !second_key |=> $stable(pll_cfg));

    // R8: effective connect never without enable
    assert_conn_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
        pll_connect |-> pll_enable);

    // R9: clock select requires connect and lock
    assert_clk_sel_R9: assert property (@(posedge clk) disable iff (rst)
        clk_sel |-> (pll_connect && lock_in));

    // R10: power-down clears the active enable at the next edge
    assert_pd_clears_R10: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> (!pll_enable && !pll_connect));

    // R10: once off, enable stays off until a 0x55 feed write
    assert_off_until_feed_R10: assert property (@(posedge clk) disable iff (rst)
        (!pll_enable && !second_key) |=> !pll_enable);

    // R11: status readback one cycle after the read
    assert_stat_read_R11: assert property (@(posedge clk) disable iff (rst)
        (re && !we && addr == STAT_ADDR) |=>
        rdata == DATA_W'({$past(lock_in), $past(pll_connect), $past(pll_enable)}));
endmodule

bind pllfeed_unit pllfeed_unit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE)
) chk_i (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wbyte(wdata[7:0]),
    .re(re), .rdata(rdata), .lock_in(lock_in), .pd_req(pd_req),
    .pll_enable(pll_enable), .pll_connect(pll_connect),
    .pll_cfg(pll_cfg), .clk_sel(clk_sel)
);

// File: tb/pllfeed_unit_tb.sv
`timescale 1ns/1ps
module pllfeed_unit_tb_top;

    localparam logic [31:0] A_CTRL = 32'h400F_C000;
    localparam logic [31:0] A_CFG  = 32'h400F_C004;
    localparam logic [31:0] A_STAT = 32'h400F_C008;
    localparam logic [31:0] A_FEED = 32'h400F_C00C;
    localparam logic [31:0] A_HOLE = 32'h400F_C100;
    localparam logic [31:0] A_OUT0 = 32'h400F_BFFC;
    localparam logic [31:0] A_OUT1 = 32'h4010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        lock_in = 1'b0;
    logic        pd_req = 1'b0;
    logic        pll_enable, pll_connect, clk_sel;
    logic [31:0] pll_cfg;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pllfeed_unit dut_i (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
        .re(re), .rdata(rdata), .lock_in(lock_in), .pd_req(pd_req),
        .pll_enable(pll_enable), .pll_connect(pll_connect),
        .pll_cfg(pll_cfg), .clk_sel(clk_sel)
    );

    // behavioural model state
    bit        m_pen, m_pcn, m_aen, m_acn, m_armed;
    bit [31:0] m_pcfg, m_acfg, m_rd;

    always @(posedge clk) begin
        bit        inwin, fire;
        bit [13:0] ofs;
        started = 1;
        if (rst) begin
            m_pen = 0; m_pcn = 0; m_aen = 0; m_acn = 0; m_armed = 0;
            m_pcfg = 0; m_acfg = 0; m_rd = 0;
        end else begin
            inwin = (addr[31:14] == 18'h1003F);
            ofs   = addr[13:0];
            m_rd  = 0;
            if (re && !we && inwin) begin
                if (ofs == 14'h000) m_rd = {30'd0, m_pcn, m_pen};
                else if (ofs == 14'h004) m_rd = m_pcfg;
                else if (ofs == 14'h008) m_rd = {29'd0, lock_in, m_aen & m_acn, m_aen};
            end
            fire = 0;
            if ((we || re) && inwin) begin
                if (we && ofs == 14'h00C) begin
                    if (wdata[7:0] == 8'hAA) m_armed = 1;
                    else begin
                        fire    = m_armed && (wdata[7:0] == 8'h55);
                        m_armed = 0;
                    end
                end else m_armed = 0;
            end
            if (we && inwin && ofs == 14'h000) begin m_pen = wdata[0]; m_pcn = wdata[1]; end
            if (we && inwin && ofs == 14'h004) m_pcfg = wdata;
            if (fire) begin m_aen = m_pen; m_acn = m_pcn; m_acfg = m_pcfg; end
            if (pd_req) begin m_aen = 0; m_acn = 0; end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R3 model pll_enable", 32'(pll_enable), 32'(m_aen));
            chk("R8 model pll_connect", 32'(pll_connect), 32'(m_aen & m_acn));
            chk("R3 model pll_cfg", pll_cfg, m_acfg);
            chk("R9 model clk_sel", 32'(clk_sel), 32'(m_aen & m_acn & lock_in));
            chk("R11 model rdata", rdata, m_rd);
        end
    end

    task automatic drive(input logic w, input logic r, input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        we = w; re = r; addr = a; wdata = d; pd_req = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d); drive(1, 0, a, d); endtask
    task automatic rd(input logic [31:0] a); drive(0, 1, a, 0); endtask
    task automatic idle(); drive(0, 0, 0, 0); endtask
    task automatic feed(); wr(A_FEED, 32'hAA); wr(A_FEED, 32'h55); idle(); endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 enable", 32'(pll_enable), 0);
        chk("R1 connect", 32'(pll_connect), 0);
        chk("R1 cfg", pll_cfg, 0);
        chk("R1 rdata", rdata, 0);
        rst = 1'b0;

        // R2 pending only
        wr(A_CTRL, 32'h3); wr(A_CFG, 32'h1234_5678); idle();
        chk("R2 enable unchanged", 32'(pll_enable), 0);
        chk("R2 cfg unchanged", pll_cfg, 0);
        rd(A_CTRL); idle();
        chk("R2 ctrl readback", rdata, 32'h3);
        rd(A_CFG); idle();
        chk("R2 cfg readback", rdata, 32'h1234_5678);
        idle();
        chk("R11 rdata idle zero", rdata, 0);

        // R3 commit with an idle gap
        wr(A_FEED, 32'hAA); idle(); wr(A_FEED, 32'h55); idle();
        chk("R3 enable", 32'(pll_enable), 1);
        chk("R3 connect", 32'(pll_connect), 1);
        chk("R3 cfg", pll_cfg, 32'h1234_5678);
        chk("R9 no lock", 32'(clk_sel), 0);
        lock_in = 1'b1; #1;
        chk("R9 locked", 32'(clk_sel), 1);

        // R4 aborts
        wr(A_CFG, 32'hABCD_EF01);
        wr(A_FEED, 32'hAA); rd(A_CTRL); wr(A_FEED, 32'h55); idle();
        chk("R4 read aborts", pll_cfg, 32'h1234_5678);
        wr(A_FEED, 32'hAA); wr(A_HOLE, 32'h1); wr(A_FEED, 32'h55); idle();
        chk("R4 hole write aborts", pll_cfg, 32'h1234_5678);
        wr(A_FEED, 32'hAA); rd(A_FEED); wr(A_FEED, 32'h55); idle();
        chk("R4 feed read aborts", pll_cfg, 32'h1234_5678);

        // R5 wrong bytes
        wr(A_FEED, 32'hAA); wr(A_FEED, 32'h54); idle();
        chk("R5 wrong second", pll_cfg, 32'h1234_5678);
        wr(A_FEED, 32'hA5); wr(A_FEED, 32'h55); idle();
        chk("R5 wrong first", pll_cfg, 32'h1234_5678);
        wr(A_FEED, 32'h55); idle();
        chk("R5 lone second", pll_cfg, 32'h1234_5678);

        // R6 repeated first key
        wr(A_FEED, 32'hAA); wr(A_FEED, 32'hAA); wr(A_FEED, 32'h55); idle();
        chk("R6 restart", pll_cfg, 32'hABCD_EF01);

        // R7 out-of-window traffic
        wr(A_CFG, 32'h0000_0777);
        wr(A_FEED, 32'hAA); wr(A_OUT0, 32'h5); rd(A_OUT1); wr(A_FEED, 32'h55); idle();
        chk("R7 outside ignored", pll_cfg, 32'h0000_0777);
        rd(A_OUT1); idle();
        chk("R11 outside read zero", rdata, 0);

        // R8 connect without enable
        wr(A_CTRL, 32'h2); feed();
        chk("R8 enable off", 32'(pll_enable), 0);
        chk("R8 connect masked", 32'(pll_connect), 0);
        chk("R9 masked", 32'(clk_sel), 0);
        rd(A_STAT); idle();
        chk("R11 stat", rdata, 32'h4);
        rd(A_CTRL); idle();
        chk("R2 raw ctrl", rdata, 32'h2);
        wr(A_CTRL, 32'h1); feed();
        chk("R8 enable only", 32'(pll_enable), 1);
        chk("R8 connect off", 32'(pll_connect), 0);
        wr(A_CTRL, 32'h3); feed();
        chk("R9 full", 32'(clk_sel), 1);
        rd(A_STAT); idle();
        chk("R11 stat full", rdata, 32'h7);

        // R10 power-down
        @(posedge clk); #1; pd_req = 1'b1;
        idle();
        chk("R10 enable cleared", 32'(pll_enable), 0);
        chk("R10 connect cleared", 32'(pll_connect), 0);
        chk("R10 cfg kept", pll_cfg, 32'h0000_0777);
        repeat (4) idle();
        chk("R10 stays off", 32'(pll_enable), 0);
        rd(A_CTRL); idle();
        chk("R10 pending kept", rdata, 32'h3);
        wr(A_CFG, 32'h0000_55AA);
        wr(A_FEED, 32'hAA);
        @(posedge clk); #1; we = 1'b1; re = 1'b0; addr = A_FEED; wdata = 32'h55; pd_req = 1'b1;
        idle();
        chk("R10 pd wins", 32'(pll_enable), 0);
        chk("R10 cfg commits", pll_cfg, 32'h0000_55AA);
        feed();
        chk("R10 refeed", 32'(pll_enable), 1);

        // R1 reset again
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 re-reset enable", 32'(pll_enable), 0);
        chk("R1 re-reset cfg", pll_cfg, 0);
        rst = 1'b0;
        rd(A_CFG); idle();
        chk("R1 pending cleared", rdata, 0);

        repeat (2) idle();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule